// File: doc/BRIEF.md
# 24-bit Floating-Point Arithmetic Unit

This block is a pipelined arithmetic unit for a compact 24-bit floating-point word. It adds, subtracts and multiplies two such words. It also converts a signed fixed-point integer into the float word, and converts a float word back into a saturated integer. A new operation can enter on every clock. Each result appears on the output exactly two cycles after its operands, with a valid strobe.

A word packs a 7-bit exponent in bits [23:17], a sign in bit [16] (0 means positive, 1 means negative) and a 16-bit fraction in bits [15:0]. The value is (-1)^sign x (fraction / 2^15) x 2^(exponent - 64). A normalized fraction therefore holds a value in [1, 2) and has bit 15 set. Examples: 1.0 is 24'h808000, 2.0 is 24'h828000, 0.5 is 24'h7E8000 and -1.0 is 24'h818000.

The unit does not round: it truncates. It has no infinities, NaNs or denormals. A result that is too large saturates, and a result that is too small flushes to zero. The fixed-point width is a parameter (default 16 bits). Its integer is carried in the low bits of operand `a` on the way in, and comes out sign-extended to 24 bits.

Top module: `fp24_alu`

## Requirements
- R1: With `in_valid` high at a rising edge, `out_valid` is high after the second following edge and carries that operation's result; with `in_valid` low, `out_valid` is low two edges later. Back-to-back operations on consecutive cycles each produce their own result.
- R2: Any operand whose exponent field is 0 is treated as zero. Every zero float result is the all-zero word 24'h000000.
- R3: Opcode 2 multiplies. The result sign is the XOR of the operand signs, the exponent is ea + eb - 64, and the 16x16 fraction product is renormalized by at most one position.
- R4: Opcode 0 adds a + b and opcode 1 subtracts a - b. The smaller magnitude is shifted right by the exponent difference, and it is treated as zero when the difference exceeds 17. Exact cancellation gives zero.
- R5: Every nonzero float result has fraction bit 15 set. Bits below the kept 16 fraction bits are discarded (truncation), and a cancelled sum is renormalized by its leading-zero count.
- R6: A float result whose exponent would exceed 127 saturates to exponent 127 and fraction 16'hFFFF, keeping its sign.
- R7: A float result whose exponent would fall below 1 flushes to 24'h000000.
- R8: Opcode 3 converts the signed two's-complement integer in a[FIX_W-1:0] into an exact float word. An integer of 0 gives 24'h000000.
- R9: Opcode 4 converts float a to a signed integer, truncating toward zero. The integer is sign-extended across all 24 result bits.
- R10: In the float-to-integer conversion, magnitudes of 2^(FIX_W-1) or more saturate to 2^(FIX_W-1)-1 for positive inputs and to -2^(FIX_W-1) for negative inputs.
- R11: While `rst` is high at a rising edge, the pipeline empties: `out_valid` and `result` are 0 after that edge, and operations in flight are dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Opcode: 0 add, 1 subtract, 2 multiply, 3 int-to-float, 4 float-to-int |
| a | input | 24 | First operand (float word, or integer in low FIX_W bits) |
| b | input | 24 | Second operand (float word) |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| result | output | 24 | Float word, or sign-extended integer for opcode 4 |

## Verification
Any internal fault reaches the ports on the very output cycle of the operation it touches, two edges after issue, because there is no feedback state. A faulty alignment shift or magnitude compare shows up as a wrong low-order fraction bit or a wrong sign on a sum. A faulty leading-one search shows up as an exponent that is off by the shift error, together with a fraction that has lost its leading one. A lost pipeline valid shows up at once as a missing or extra strobe. The vectors are chosen so that each path (alignment cutoff, truncation, cancellation, saturation at both ends, and conversion limits) yields a word that differs from its neighbours in a known bit.

// File: rtl/fp24_pkg.sv
package fp24_pkg;

    localparam int WORD_W    = 24;
    localparam int EXP_W     = 7;
    localparam int FRAC_W    = 16;
    localparam int BIAS      = 64;
    localparam int EXP_TOP   = (1 << EXP_W) - 1;
    localparam int ONE_POS   = 2 * FRAC_W - 2;      // bit of 1.0 in the raw magnitude
    localparam int RAW_W     = ONE_POS + 4;         // headroom for carry and product
    localparam int POS_W     = $clog2(RAW_W);
    localparam int ALIGN_LIM = FRAC_W + 1;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_MUL = 3'd2,
        OP_I2F = 3'd3,
        OP_F2I = 3'd4
    } fp_op_e;

    typedef struct packed {
        logic [EXP_W-1:0]  exp;
        logic              sign;
        logic [FRAC_W-1:0] frac;
    } fp24_t;

    // Unnormalized intermediate: value = mag * 2^(exp - BIAS - ONE_POS)
    typedef struct packed {
        logic              direct;   // fixed word already final
        logic              sign;
        logic signed [10:0] exp;
        logic [RAW_W-1:0]  mag;
        logic [WORD_W-1:0] fixed;
    } raw_t;

    function automatic logic [POS_W-1:0] lead_one(input logic [RAW_W-1:0] v);
        logic [POS_W-1:0] pos;
        pos = '0;
        for (int i = 0; i < RAW_W; i++) begin
            if (v[i]) pos = POS_W'(i);
        end
        return pos;
    endfunction

endpackage

// File: rtl/fp24_front.sv
module fp24_front
    import fp24_pkg::*;
#(
    parameter int FIX_W = 16
) (
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output raw_t              raw
);
    localparam int EXT_W = FRAC_W + FIX_W;
    localparam int LOW_Z = ONE_POS - (FRAC_W - 1);

    fp24_t fa, fb;
    assign fa = a;
    assign fb = b;

    logic              a_zero, b_zero;
    logic [FRAC_W-1:0] ma, mb;
    assign a_zero = (fa.exp == '0);
    assign b_zero = (fb.exp == '0);
    assign ma     = a_zero ? '0 : fa.frac;
    assign mb     = b_zero ? '0 : fb.frac;

    // Add / subtract: order by magnitude, align the smaller one
    logic              sb_eff, a_ge;
    logic [EXP_W-1:0]  be, se, dif;
    logic [FRAC_W-1:0] bm, sm;
    logic              bs, ss;
    logic [RAW_W-1:0]  bx, sx, sum;

    always_comb begin
        sb_eff = fb.sign ^ (op == OP_SUB);
        a_ge   = {fa.exp, ma} >= {fb.exp, mb};
        be = a_ge ? fa.exp : fb.exp;
        se = a_ge ? fb.exp : fa.exp;
        bm = a_ge ? ma : mb;
        sm = a_ge ? mb : ma;
        bs = a_ge ? fa.sign : sb_eff;
        ss = a_ge ? sb_eff : fa.sign;
        dif = be - se;
        bx  = {{(RAW_W-FRAC_W-LOW_Z){1'b0}}, bm, {LOW_Z{1'b0}}};
        sx  = {{(RAW_W-FRAC_W-LOW_Z){1'b0}}, sm, {LOW_Z{1'b0}}};
        sx  = (dif > EXP_W'(ALIGN_LIM)) ? '0 : (sx >> dif);
        sum = (bs == ss) ? (bx + sx) : (bx - sx);
    end

    // Multiply
    logic [2*FRAC_W-1:0] prod;
    logic signed [10:0]  mul_e;
    assign prod  = (2*FRAC_W)'(ma) * (2*FRAC_W)'(mb);
    assign mul_e = $signed({4'b0, fa.exp}) + $signed({4'b0, fb.exp}) - 11'sd64;

    // Integer to float
    logic [FIX_W-1:0] xi, xm;
    assign xi = a[FIX_W-1:0];
    assign xm = xi[FIX_W-1] ? (~xi + 1'b1) : xi;

    // Float to integer, truncating toward zero, saturating
    logic signed [8:0] k;
    logic [EXT_W-1:0]  ext, shd;
    logic [6:0]        sh;
    logic [FIX_W-1:0]  fmag, fx;

    always_comb begin
        k    = $signed({2'b0, fa.exp}) - 9'sd64;
        ext  = {fa.frac, {FIX_W{1'b0}}};
        sh   = 7'(FIX_W + FRAC_W - 1) - 7'(k[6:0]);
        shd  = ext >> sh;
        fmag = shd[FIX_W-1:0];
        if (a_zero || k[8])
            fx = '0;
        else if (k >= 9'(FIX_W - 1))
            fx = fa.sign ? {1'b1, {(FIX_W-1){1'b0}}} : {1'b0, {(FIX_W-1){1'b1}}};
        else
            fx = fa.sign ? (~fmag + 1'b1) : fmag;
    end

    always_comb begin
        raw        = '0;
        raw.fixed  = {{(WORD_W-FIX_W){fx[FIX_W-1]}}, fx};
        unique case (op)
            OP_ADD, OP_SUB: begin
                raw.sign = bs;
                raw.exp  = $signed({4'b0, be});
                raw.mag  = sum;
            end
            OP_MUL: begin
                raw.sign = fa.sign ^ fb.sign;
                raw.exp  = mul_e;
                raw.mag  = RAW_W'(prod);
            end
            OP_I2F: begin
                raw.sign = xi[FIX_W-1];
                raw.exp  = 11'(BIAS + ONE_POS);
                raw.mag  = RAW_W'(xm);
            end
            OP_F2I: raw.direct = 1'b1;
            default: raw.mag = '0;
        endcase
    end

endmodule

// File: rtl/fp24_back.sv
module fp24_back
    import fp24_pkg::*;
(
    input  raw_t              raw,
    output logic [WORD_W-1:0] word
);
    logic [POS_W-1:0]   p;
    logic signed [10:0] ne;
    logic [RAW_W-1:0]   norm;
    fp24_t              f;

    always_comb begin
        p    = lead_one(raw.mag);
        ne   = raw.exp + $signed({{(11-POS_W){1'b0}}, p}) - 11'(ONE_POS);
        norm = raw.mag << (POS_W'(RAW_W - 1) - p);
        f.exp  = ne[EXP_W-1:0];
        f.sign = raw.sign;
        f.frac = norm[RAW_W-1 -: FRAC_W];
        if (raw.direct)
            word = raw.fixed;
        else if (raw.mag == '0 || ne < 11'sd1)
            word = '0;
        else if (ne > 11'(EXP_TOP))
            word = {EXP_W'(EXP_TOP), raw.sign, {FRAC_W{1'b1}}};
        else
            word = f;
    end

endmodule

// File: rtl/fp24_alu.sv
module fp24_alu
    import fp24_pkg::*;
#(
    parameter int FIX_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [2:0]        op,
    input  logic [WORD_W-1:0] a,
    input  logic [WORD_W-1:0] b,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    raw_t              raw_d, raw_q;
    logic              s1_valid;
    logic              out_fix;
    logic [WORD_W-1:0] word;

    fp24_front #(.FIX_W(FIX_W)) u_front (
        .op  (op),
        .a   (a),
        .b   (b),
        .raw (raw_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            raw_q    <= '0;
        end else begin
            s1_valid <= in_valid;
            if (in_valid) raw_q <= raw_d;
        end
    end

    fp24_back u_back (
        .raw  (raw_q),
        .word (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_fix   <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                result  <= word;
                out_fix <= raw_q.direct;
            end
        end
    end

    // Two-cycle latency in both directions (R1)
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> ##2 out_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> ##2 !out_valid);

    // Zero floats are canonical (R2)
    p_zero_canon_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fix && result[WORD_W-1 -: EXP_W] == '0) |-> (result == '0));

    // Nonzero floats are normalized (R5)
    p_normalized_r5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_fix && result[WORD_W-1 -: EXP_W] != '0) |-> result[FRAC_W-1]);

    // Product sign follows the operand signs (R3)
    p_mul_sign_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == OP_MUL && a[WORD_W-1 -: EXP_W] != '0 && b[WORD_W-1 -: EXP_W] != '0)
        |-> ##2 (result[WORD_W-1 -: EXP_W] == '0 || result[FRAC_W] == $past(a[FRAC_W] ^ b[FRAC_W], 2)));

    // Integer output is sign-extended (R9)
    p_fix_ext_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fix) |-> (&result[WORD_W-1:FIX_W-1] || ~|result[WORD_W-1:FIX_W-1]));

endmodule

// File: tb/fp24_alu_tb.sv
module fp24_alu_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [23:0] a = '0;
    logic [23:0] b = '0;
    logic        out_valid;
    logic [23:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fp24_alu #(.FIX_W(16)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .op        (op),
        .a         (a),
        .b         (b),
        .out_valid (out_valid),
        .result    (result)
    );

    // {op, a, b, expected, requirement number}
    localparam int NV = 27;
    localparam logic [82:0] VEC [NV] = '{
        {3'd0, 24'h808000, 24'h808000, 24'h828000, 8'd4},  // R4 1+1=2
        {3'd0, 24'h80C000, 24'h80C000, 24'h82C000, 8'd4},  // R4 1.5+1.5=3
        {3'd1, 24'h808000, 24'h808000, 24'h000000, 8'd4},  // R4 cancel
        {3'd1, 24'h808000, 24'h828000, 24'h818000, 8'd4},  // R4 1-2=-1
        {3'd0, 24'h808000, 24'h7E8000, 24'h80C000, 8'd4},  // R4 1+0.5
        {3'd2, 24'h80C000, 24'h828000, 24'h82C000, 8'd3},  // R3 1.5*2
        {3'd2, 24'h80C000, 24'h80C000, 24'h829000, 8'd3},  // R3 1.5*1.5 renorm
        {3'd2, 24'h818000, 24'h828000, 24'h838000, 8'd3},  // R3 -1*2
        {3'd2, 24'h808000, 24'h000000, 24'h000000, 8'd2},  // R2 times zero
        {3'd0, 24'h808000, 24'h000000, 24'h808000, 8'd2},  // R2 plus zero
        {3'd3, 24'h000001, 24'h000000, 24'h808000, 8'd8},  // R8 1
        {3'd3, 24'h00FFFD, 24'h000000, 24'h83C000, 8'd8},  // R8 -3
        {3'd3, 24'h008000, 24'h000000, 24'h9F8000, 8'd8},  // R8 -32768
        {3'd3, 24'h000000, 24'h000000, 24'h000000, 8'd8},  // R8 zero
        {3'd4, 24'h82C000, 24'h000000, 24'h000003, 8'd9},  // R9 3.0
        {3'd4, 24'h839000, 24'h000000, 24'hFFFFFE, 8'd9},  // R9 -2.25 -> -2
        {3'd4, 24'h7E8000, 24'h000000, 24'h000000, 8'd9},  // R9 0.5 -> 0
        {3'd4, 24'hA08000, 24'h000000, 24'h007FFF, 8'd10}, // R10 +65536
        {3'd4, 24'hA18000, 24'h000000, 24'hFF8000, 8'd10}, // R10 -65536
        {3'd2, 24'hFE8000, 24'h828000, 24'hFEFFFF, 8'd6},  // R6 positive overflow
        {3'd2, 24'hFF8000, 24'h828000, 24'hFFFFFF, 8'd6},  // R6 negative overflow
        {3'd2, 24'h028000, 24'h7E8000, 24'h000000, 8'd7},  // R7 underflow flush
        {3'd0, 24'h808000, 24'h5C8000, 24'h808000, 8'd4},  // R4 diff 18 dropped
        {3'd0, 24'h808000, 24'h628000, 24'h808001, 8'd4},  // R4 diff 15 aligned
        {3'd0, 24'h808000, 24'h608000, 24'h808000, 8'd5},  // R5 truncation
        {3'd1, 24'h829000, 24'h828000, 24'h7C8000, 8'd5},  // R5 lzc renorm 0.25
        {3'd1, 24'h818000, 24'h818000, 24'h000000, 8'd2}   // R2 -1-(-1)
    };

    task automatic check(input bit ok, input string req, input logic [24:0] act, input logic [24:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && result == '0, "R11 reset",
              {out_valid, result}, 25'd0);
        rst = 1'b0;

        // R1 streaming table, one operation per cycle
        for (int i = 0; i < NV + 2; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check(out_valid == 1'b1, "R1 valid", {24'd0, out_valid}, 25'd1);
                check(result == VEC[i-2][31:8], $sformatf("R%0d vec%0d", VEC[i-2][7:0], i-2),
                      {1'b0, result}, {1'b0, VEC[i-2][31:8]});
            end
            if (i < NV) begin
                in_valid = 1'b1;
                op = VEC[i][82:80];
                a  = VEC[i][79:56];
                b  = VEC[i][55:32];
            end else begin
                in_valid = 1'b0;
            end
        end

        // R1 idle: no strobe two cycles after no input
        @(negedge clk);
        check(out_valid == 1'b0, "R1 idle", {24'd0, out_valid}, 25'd0);

        // R11 reset drops an operation in flight
        in_valid = 1'b1; op = 3'd0; a = 24'h808000; b = 24'h808000;
        @(negedge clk);
        in_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && result == '0, "R11 flush",
              {out_valid, result}, 25'd0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R11 no late strobe", {24'd0, out_valid}, 25'd0);

        // R1 a single operation after reset still lands two edges later
        in_valid = 1'b1; op = 3'd2; a = 24'h828000; b = 24'h828000;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b0, "R1 not early", {24'd0, out_valid}, 25'd0);
        @(negedge clk);
        check(out_valid == 1'b1 && result == 24'h848000, "R1 single 2*2=4",
              {out_valid, result}, {1'b1, 24'h848000});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule